// File: doc/BRIEF.md
# Memory Chip-Enable Gate

This block sits between a processor's active-low memory chip-enable and a battery-backed RAM. While the system reset from the supply supervisor is inactive, the chip-enable passes straight through in the same cycle. Once that reset goes active, no new memory access may begin. The gate then blocks the chip-enable by driving it inactive (high) until the reset event is over.

If an access is already under way when reset asserts, it is not cut off at once. The block lets the low chip-enable run on for a bounded grace window of `HOLD_TICKS` clock cycles. The window counts the cycle in which reset asserts. If the input rises before the window is over, the output rises in that same cycle. In either case the output stays high for the rest of the event, whatever the input does afterwards. While the supply runs from the backup battery, the input is ignored and the output is held high.

The design is a small three-state controller (pass, grace, blocked) and a datapath. The datapath holds the grace counter and the output gating. The two parts are linked by a strobe struct.

Top module: `memGate`

## Requirements
- R1: While `sysResetN` is 1 and `rstN` is 1, `ceOutN` equals `ceInN OR battMode` in the same cycle.
- R2: If the effective input (`ceInN OR battMode`) is 1 in the first cycle with `sysResetN` at 0, `ceOutN` is 1 in every cycle until `sysResetN` returns to 1, whatever `ceInN` does.
- R3: If the effective input is 0 in the first cycle with `sysResetN` at 0 and stays 0, `ceOutN` is 0 for exactly `HOLD_TICKS` cycles. The count starts with that first cycle. `ceOutN` is 1 from then on until the event ends.
- R4: If the effective input rises during the grace window, `ceOutN` is 1 in that same cycle. It stays 1 for the rest of the event, even if `ceInN` falls again.
- R5: When `battMode` is 1, `ceOutN` is 1 in that cycle, whatever the value of `ceInN`. A `battMode` pulse during the grace window ends the grace window.
- R6: In the first cycle in which `sysResetN` is back at 1, `ceOutN` again equals the effective input.
- R7: While `rstN` is 0, the controller is in the pass state and `ceOutN` follows the effective input. If `sysResetN` is 0 when `rstN` is released, the block treats that cycle as the start of a reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the block's own state |
| ceInN | input | 1 | Active-low chip-enable from the processor |
| sysResetN | input | 1 | Active-low system reset from the supervisor |
| battMode | input | 1 | 1 while the supply runs from the backup battery |
| ceOutN | output | 1 | Gated active-low chip-enable to the memory |

## Verification
Several properties are checked on every cycle. Pass-through while reset is inactive is one. Another is that the output is forced high in battery mode. A third is that once the output is high inside a reset event, it stays high. The last is that a low output inside an event never lasts more than `HOLD_TICKS` cycles, which a run-length counter checks. Other points can only be shown by the bench's sweeps. These cover the exact length of the grace window, an early release when the input rises at each offset, and the low level at assertion that decides between grace and block. They also cover a battery pulse that lands inside the window and the same-cycle return to pass-through.

// File: rtl/memGatePkg.sv
package memGatePkg;

  typedef enum logic [1:0] {
    GS_PASS    = 2'd0,
    GS_HOLD    = 2'd1,
    GS_BLOCKED = 2'd2
  } gateState_e;

  typedef struct packed {
    logic openGate;  // output follows effective input
    logic cntStart;  // load grace counter (assertion cycle counted)
    logic cntStep;   // advance grace counter
  } gateStrobe_t;

endpackage

// File: rtl/memGateCtrl.sv
module memGateCtrl
  import memGatePkg::*;
#(
  parameter int HOLD_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sysResetN,
  input  logic        ceEff,
  input  logic        graceLast,
  output gateStrobe_t strobe,
  output gateState_e  stateQ
);

  localparam bit HAS_GRACE = (HOLD_TICKS > 1);

  gateState_e stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= GS_PASS;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD          = stateQ;
    strobe          = '0;
    unique case (stateQ)
      GS_PASS: begin
        strobe.openGate = 1'b1;
        if (!sysResetN) begin
          if (!ceEff && HAS_GRACE) begin
            stateD          = GS_HOLD;
            strobe.cntStart = 1'b1;
          end else begin
            stateD = GS_BLOCKED;
          end
        end
      end
      GS_HOLD: begin
        strobe.openGate = 1'b1;
        if (sysResetN)        stateD = GS_PASS;
        else if (ceEff)       stateD = GS_BLOCKED;
        else if (graceLast)   stateD = GS_BLOCKED;
        else                  strobe.cntStep = 1'b1;
      end
      GS_BLOCKED: begin
        strobe.openGate = sysResetN;
        if (sysResetN) stateD = GS_PASS;
      end
      default: stateD = GS_PASS;
    endcase
  end

  // R3: the grace state is only ever reached from pass
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == GS_HOLD && $past(stateQ) != GS_HOLD) |-> $past(stateQ) == GS_PASS); // R3

endmodule

// File: rtl/memGateDp.sv
module memGateDp
  import memGatePkg::*;
#(
  parameter int HOLD_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  input  logic        ceEff,
  output logic        graceLast,
  output logic        ceOutN
);

  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] graceCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               graceCnt <= '0;
    else if (strobe.cntStart) graceCnt <= CW'(1);
    else if (strobe.cntStep)  graceCnt <= graceCnt + CW'(1);
  end

  assign graceLast = (graceCnt == CW'(HOLD_TICKS - 1));
  assign ceOutN    = strobe.openGate ? ceEff : 1'b1;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntStep |-> graceCnt < CW'(HOLD_TICKS)); // R3

endmodule

// File: rtl/memGate.sv
module memGate
  import memGatePkg::*;
#(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceInN,
  input  logic sysResetN,
  input  logic battMode,
  output logic ceOutN
);

  localparam int RW = $clog2(HOLD_TICKS + 2);

  logic        ceEff;
  logic        graceLast;
  gateStrobe_t strobe;
  gateState_e  stateQ;

  assign ceEff = ceInN | battMode;

  memGateCtrl #(.HOLD_TICKS(HOLD_TICKS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sysResetN (sysResetN),
    .ceEff     (ceEff),
    .graceLast (graceLast),
    .strobe    (strobe),
    .stateQ    (stateQ)
  );

  memGateDp #(.HOLD_TICKS(HOLD_TICKS)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ceEff     (ceEff),
    .graceLast (graceLast),
    .ceOutN    (ceOutN)
  );

  // checker state: history valid flag and low-run length inside an event
  logic          pastValid;
  logic [RW-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      lowRun    <= '0;
    end else begin
      pastValid <= 1'b1;
      if (!sysResetN && !ceOutN) begin
        if (lowRun != RW'(HOLD_TICKS + 1)) lowRun <= lowRun + RW'(1);
      end else begin
        lowRun <= '0;
      end
    end
  end

  AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    sysResetN |-> ceOutN == (ceInN | battMode)); // R1

  AST_BATT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    battMode |-> ceOutN); // R5

  AST_HIGH_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !sysResetN && $past(!sysResetN) && $past(ceOutN)) |-> ceOutN); // R4

  AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (!sysResetN && !ceOutN) |-> lowRun < RW'(HOLD_TICKS)); // R3

endmodule

// File: tb/sim_memGate.sv
`timescale 1ns/1ps
module sim_memGate;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN, ceInN, sysResetN, battMode;
  logic ceOutN;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // reference state derived from the requirements
  bit mPrevRst  = 1'b1;
  int mK        = 0;
  bit mLowStart = 1'b0;
  bit mStillLow = 1'b0;

  always #4 clk = ~clk;

  memGate #(.HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .ceInN(ceInN),
    .sysResetN(sysResetN), .battMode(battMode), .ceOutN(ceOutN)
  );

  task automatic step(input bit rn, input bit ce, input bit srn, input bit bm);
    bit eff;
    bit exp;
    string tag;
    @(negedge clk);
    rstN = rn; ceInN = ce; sysResetN = srn; battMode = bm;
    #1;
    eff = ce | bm;
    if (!rn) begin
      exp = eff; tag = "R7"; mPrevRst = 1'b1;
    end else if (srn) begin
      exp = eff; tag = mPrevRst ? "R1" : "R6"; mPrevRst = 1'b1;
    end else begin
      if (mPrevRst) begin
        mK = 0; mLowStart = !eff; mStillLow = !eff;
      end else begin
        mK++;
      end
      if (eff) mStillLow = 1'b0;
      exp = (mStillLow && mK < HOLD) ? 1'b0 : 1'b1;
      if (bm)              tag = "R5";
      else if (!mLowStart) tag = "R2";
      else if (mStillLow || (mK >= HOLD)) tag = "R3";
      else                 tag = "R4";
      mPrevRst = 1'b0;
    end
    checkCnt++;
    if (ceOutN !== exp) begin
      failCnt++;
      $display("FAIL %s: ceOutN=%b expected %b (ce=%b sysRst=%b batt=%b k=%0d)",
               tag, ceOutN, exp, ce, srn, bm, mK);
    end
  endtask

  initial begin
    rstN = 1'b0; ceInN = 1'b1; sysResetN = 1'b1; battMode = 1'b0;
    // R7: block reset, output follows input
    step(0, 0, 1, 0);
    step(0, 1, 1, 0);
    step(0, 0, 1, 1);
    step(1, 0, 1, 0);
    // sweep of reset events
    for (int low = 0; low < 2; low++)
      for (int riseAt = 1; riseAt < 8; riseAt++)
        for (int bsel = 0; bsel < 3; bsel++)
          for (int lsel = 0; lsel < 2; lsel++) begin
            int len    = (lsel == 0) ? 3 : 7;
            int battAt = (bsel == 0) ? 99 : ((bsel == 1) ? 0 : 2);
            for (int p = 0; p < 3; p++) step(1, p[0], 1, 0);           // R1
            for (int k = 0; k < len; k++) begin
              bit ce;
              if (low == 1) ce = (k < riseAt) ? 1'b0 : !(((k - riseAt) % 2) != 0);
              else          ce = (k == 0) ? 1'b1 : k[0];
              step(1, ce, 0, k == battAt);                             // R2 R3 R4 R5
            end
            step(1, 0, 1, 0);                                          // R6
            step(1, 1, 1, 0);
          end
    // R7: block reset inside an event, released while sysResetN still low
    step(1, 1, 0, 0);
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    for (int k = 0; k < HOLD + 2; k++) step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule